// File: doc/BRIEF.md
# Shared-Bus ROM/RAM Access Controller

This block sits between a synchronous host and one external package that carries two asynchronous byte-wide memories: an 18-bit-addressed read-only region and a smaller static RAM region. Both memories share one address bus and one data bus. The host raises a one-cycle request with a target flag (ROM or RAM), a write flag, an address and write data. The controller then runs the bus cycle by driving two active-low selects, an active-low output enable, an active-low write enable, the address lines and the enable of the host-side data driver.

All bus phases are counted in clock cycles. The counts come from nanosecond parameters by rounding up against the clock period, with a floor of one cycle. A read holds select and output enable for the longest of the access and output-enable delays. It then captures the data and leaves a bus-release gap before anything else may drive. A write lowers write enable one cycle ahead of the RAM select. It drives data over the whole overlap and one cycle after it, and stretches the overlap so the full cycle meets the write-cycle minimum.

RAM addresses are clipped above the RAM size's top address bit, which is set by a parameter. A write aimed at the ROM is refused with an error pulse and never reaches the bus.

Top module: `romram_bus_ctrl`

## Requirements
- R1: `rom_cs_n` and `ram_cs_n` are never low together. While `busy` is low, both selects, `oe_n` and `we_n` are high and `bus_drive` is low. After reset `rdy`, `err` and `busy` are 0.
- R2: A ROM read (`req_ram`=0, `req_write`=0) holds `rom_cs_n` and `oe_n` low with `we_n` high for RD = max(ceil(T_ACC_NS/CLK_NS), ceil(T_OE_NS/CLK_NS)) cycles. It captures `bus_din` on the last of them into `rd_data`, and `rdy` is seen RD+1 cycles after the request edge.
- R3: A RAM read (`req_ram`=1, `req_write`=0) holds `ram_cs_n` and `oe_n` low with `we_n` high for RD cycles and returns the byte last written to the same clipped address.
- R4: A RAM write lowers `we_n` one cycle before `ram_cs_n`. The overlap of both lows lasts PW = max(ceil(T_WP_NS/CLK_NS), ceil(T_DW_NS/CLK_NS), ceil(T_WC_NS/CLK_NS)-2, 1) cycles. `bus_drive` is high with a constant `bus_dout` through the overlap and one cycle after it, and `rdy` is seen PW+3 cycles after the request edge.
- R5: During RAM cycles, address bits above RAM_MSB are driven 0, so addresses that differ only there alias. ROM cycles drive all 18 bits unchanged.
- R6: `bus_drive` is never high while `oe_n` is low. It stays low for at least TA = ceil(T_TA_NS/CLK_NS) cycles after `oe_n` returns high.
- R7: A request with `req_ram`=0 and `req_write`=1 gives a one-cycle `err` in the next cycle. It starts no bus activity and leaves RAM contents unchanged.
- R8: `rdy` and `err` are single-cycle pulses. A request made while `busy` is high is ignored. A request made in the cycle where a write's `rdy` is seen is accepted.
- R9: Every phase count is the ceiling of its nanosecond value over CLK_NS, never less than one cycle, so latencies follow the parameters exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-cycle request strobe, sampled when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ram | input | 1 | 1 = RAM target, 0 = ROM target |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rdy | output | 1 | Completion pulse (write done or read data valid) |
| err | output | 1 | Rejected-request pulse |
| busy | output | 1 | Bus cycle in progress |
| rd_data | output | DATA_W | Last captured read byte |
| rom_cs_n | output | 1 | ROM select, active low |
| ram_cs_n | output | 1 | RAM select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| bus_addr | output | ADDR_W | Address lines |
| bus_dout | output | DATA_W | Data toward the device |
| bus_drive | output | 1 | Host data driver enable |
| bus_din | input | DATA_W | Data from the device |

## Verification
Two events can share a cycle: the `rdy` pulse that ends a write, and the acceptance of the next request. The bench provokes this by issuing each new request in the same cycle it sees a write's `rdy`, so a read or write starts at once behind the write. It judges the result from the returned bytes, the measured overlap lengths and a bus-contention monitor in the device model. Requests made while `busy` is high are also provoked in the middle of a read. Their effect is judged afterwards by reading back the target address.

// File: rtl/romram_pkg.sv
package romram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_ACT = 3'd1,
    ST_RD_REL = 3'd2,
    ST_WR_SET = 3'd3,
    ST_WR_PUL = 3'd4,
    ST_WR_END = 3'd5
  } seq_state_t;

  // Round a nanosecond figure up to whole clocks, never below one.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Bits at or below msb kept, the rest cleared.
  function automatic logic [31:0] keep_mask(input int msb);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = (i <= msb);
    return m;
  endfunction

endpackage

// File: rtl/romram_addr_map.sv
module romram_addr_map #(
  parameter int ADDR_W  = 18,
  parameter int RAM_MSB = 16
) (
  input  logic              is_ram,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  import romram_pkg::*;

  generate
    if (RAM_MSB >= ADDR_W - 1) begin : g_full
      assign addr_out = addr_in;
    end else begin : g_clip
      localparam logic [31:0] MASK32 = keep_mask(RAM_MSB);
      localparam logic [ADDR_W-1:0] MASK = MASK32[ADDR_W-1:0];
      assign addr_out = is_ram ? (addr_in & MASK) : addr_in;
    end
  endgenerate

endmodule

// File: rtl/romram_seq.sv
module romram_seq #(
  parameter int RD_CYC = 14,
  parameter int PW_CYC = 12,
  parameter int TA_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic req_write,
  input  logic req_ram,
  input  logic cur_ram,
  output logic accept,
  output logic cap_en,
  output logic rom_cs_n,
  output logic ram_cs_n,
  output logic oe_n,
  output logic we_n,
  output logic drive,
  output logic rdy,
  output logic err,
  output logic busy
);
  import romram_pkg::*;

  localparam int CMAX  = max2(max2(RD_CYC, PW_CYC), TA_CYC);
  localparam int CNT_W = $clog2(CMAX + 1);

  seq_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic             rom_wr;

  assign rom_wr = req_write && !req_ram;
  assign accept = (st == ST_IDLE) && req && !rom_wr;
  assign cap_en = (st == ST_RD_ACT) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
      rdy <= 1'b0;
      err <= 1'b0;
    end else begin
      rdy <= 1'b0;
      err <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req && rom_wr) begin
            err <= 1'b1;
          end else if (req && req_write) begin
            st <= ST_WR_SET;
          end else if (req) begin
            st  <= ST_RD_ACT;
            cnt <= CNT_W'(RD_CYC - 1);
          end
        end
        ST_RD_ACT: begin
          if (cnt == '0) begin
            st  <= ST_RD_REL;
            cnt <= CNT_W'(TA_CYC - 1);
            rdy <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RD_REL: begin
          if (cnt == '0) st <= ST_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        ST_WR_SET: begin
          st  <= ST_WR_PUL;
          cnt <= CNT_W'(PW_CYC - 1);
        end
        ST_WR_PUL: begin
          if (cnt == '0) st <= ST_WR_END;
          else           cnt <= cnt - 1'b1;
        end
        ST_WR_END: begin
          st  <= ST_IDLE;
          rdy <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rom_cs_n = !((st == ST_RD_ACT) && !cur_ram);
    ram_cs_n = !(((st == ST_RD_ACT) && cur_ram) || (st == ST_WR_PUL));
    oe_n     = (st != ST_RD_ACT);
    we_n     = !((st == ST_WR_SET) || (st == ST_WR_PUL));
    drive    = (st == ST_WR_SET) || (st == ST_WR_PUL) || (st == ST_WR_END);
    busy     = (st != ST_IDLE);
  end

endmodule

// File: rtl/romram_bus_ctrl.sv
module romram_bus_ctrl #(
  parameter int CLK_NS   = 5,
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 8,
  parameter int RAM_MSB  = 16,
  parameter int T_ACC_NS = 70,
  parameter int T_OE_NS  = 35,
  parameter int T_WP_NS  = 60,
  parameter int T_DW_NS  = 30,
  parameter int T_WC_NS  = 70,
  parameter int T_TA_NS  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_write,
  input  logic              req_ram,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rdy,
  output logic              err,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data,
  output logic              rom_cs_n,
  output logic              ram_cs_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_drive,
  input  logic [DATA_W-1:0] bus_din
);
  import romram_pkg::*;

  localparam int RD_CYC = max2(ns_to_cyc(T_ACC_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int PW_CYC = max2(max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)),
                               max2(ns_to_cyc(T_WC_NS, CLK_NS) - 2, 1));
  localparam int TA_CYC = ns_to_cyc(T_TA_NS, CLK_NS);

  logic              req_accept;
  logic              read_capture;
  logic              ram_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_clip;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  romram_addr_map #(.ADDR_W(ADDR_W), .RAM_MSB(RAM_MSB)) u_map (
    .is_ram   (req_ram),
    .addr_in  (req_addr),
    .addr_out (addr_clip)
  );

  romram_seq #(.RD_CYC(RD_CYC), .PW_CYC(PW_CYC), .TA_CYC(TA_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .req_write (req_write),
    .req_ram   (req_ram),
    .cur_ram   (ram_q),
    .accept    (req_accept),
    .cap_en    (read_capture),
    .rom_cs_n  (rom_cs_n),
    .ram_cs_n  (ram_cs_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .drive     (bus_drive),
    .rdy       (rdy),
    .err       (err),
    .busy      (busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (req_accept) begin
        ram_q   <= req_ram;
        addr_q  <= addr_clip;
        wdata_q <= req_wdata;
      end
      if (read_capture) rdata_q <= bus_din;
    end
  end

  assign bus_addr = addr_q;
  assign bus_dout = wdata_q;
  assign rd_data  = rdata_q;

endmodule

// File: rtl/romram_bus_chk.sv
module romram_bus_chk #(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 8,
  parameter int RAM_MSB = 16,
  parameter int RD_CYC  = 14,
  parameter int PW_CYC  = 12,
  parameter int TA_CYC  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              rdy,
  input logic              err,
  input logic              rom_cs_n,
  input logic              ram_cs_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              bus_drive,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_dout,
  input logic              cap_en
);
  import romram_pkg::*;

  localparam logic [31:0] KEEP32 = keep_mask(RAM_MSB);
  localparam logic [ADDR_W-1:0] HI_BITS = ~KEEP32[ADDR_W-1:0];

  logic        overlap;
  logic [15:0] ov_cnt;
  logic [15:0] oe_cnt;
  logic [15:0] since_oe;

  assign overlap = !ram_cs_n && !we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_cnt   <= '0;
      oe_cnt   <= '0;
      since_oe <= 16'(TA_CYC);
    end else begin
      ov_cnt   <= overlap ? ov_cnt + 1'b1 : '0;
      oe_cnt   <= !oe_n ? oe_cnt + 1'b1 : '0;
      if (!oe_n)                    since_oe <= '0;
      else if (since_oe < 16'(TA_CYC)) since_oe <= since_oe + 1'b1;
    end
  end

  // R1
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs_n || ram_cs_n);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rom_cs_n && ram_cs_n && oe_n && we_n && !bus_drive));
  // R2
  rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> (!oe_n && oe_cnt == 16'(RD_CYC - 1)));
  // R4
  we_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overlap && $past(ram_cs_n)) |-> $past(!we_n));
  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(overlap) && !overlap) |-> (ov_cnt == 16'(PW_CYC)));
  // R4
  data_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overlap |-> bus_drive);
  // R4
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive && $past(bus_drive)) |-> $stable(bus_dout));
  // R5
  ram_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cs_n |-> ((bus_addr & HI_BITS) == '0));
  // R6
  no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !bus_drive);
  // R6
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> (since_oe >= 16'(TA_CYC)));
  // R7
  rom_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_cs_n |-> we_n);
  // R8
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy);
  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

endmodule

bind romram_bus_ctrl romram_bus_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_MSB(RAM_MSB),
  .RD_CYC(RD_CYC), .PW_CYC(PW_CYC), .TA_CYC(TA_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .rdy       (rdy),
  .err       (err),
  .rom_cs_n  (rom_cs_n),
  .ram_cs_n  (ram_cs_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .bus_drive (bus_drive),
  .bus_addr  (bus_addr),
  .bus_dout  (bus_dout),
  .cap_en    (read_capture)
);

// File: tb/romram_bus_ctrl_tb.sv
`timescale 1ns/1ps
module romram_bus_ctrl_tb;
  localparam int CLK_NS  = 5;
  localparam int RAM_MSB = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_write = 1'b0, req_ram = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rdy, err, busy, rom_cs_n, ram_cs_n, oe_n, we_n, bus_drive;
  logic [7:0]  rd_data, bus_dout, bus_din;
  logic [17:0] bus_addr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  romram_bus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write), .req_ram(req_ram),
    .req_addr(req_addr), .req_wdata(req_wdata), .rdy(rdy), .err(err), .busy(busy),
    .rd_data(rd_data), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .oe_n(oe_n),
    .we_n(we_n), .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_drive(bus_drive),
    .bus_din(bus_din)
  );

  // ---- bench-side arithmetic ----
  function automatic int cyc(input int ns);
    int n = 0;
    while (n * CLK_NS < ns) n++;
    if (n == 0) n = 1;
    return n;
  endfunction
  function automatic int big(input int a, input int b);
    if (a > b) return a;
    return b;
  endfunction
  function automatic int exp_rd();  return big(cyc(70), cyc(35)); endfunction
  function automatic int exp_pw();  return big(big(cyc(60), cyc(30)), big(cyc(70) - 2, 1)); endfunction
  function automatic int exp_ta();  return cyc(30); endfunction
  function automatic logic [17:0] clip(input logic ram, input logic [17:0] a);
    logic [17:0] r = a;
    if (ram) for (int i = RAM_MSB + 1; i < 18; i++) r[i] = 1'b0;
    return r;
  endfunction
  function automatic logic [7:0] rom_val(input logic [17:0] a);
    return a[7:0] ^ {a[17:16], a[13:8]} ^ 8'h3C;
  endfunction

  // ---- device model ----
  logic [7:0]  dev_mem [4096];
  logic [17:0] dev_tag [4096];
  bit          dev_v   [4096];
  logic [7:0]  ref_mem [4096];
  logic [17:0] ref_tag [4096];
  bit          ref_v   [4096];

  logic dev_out;
  assign dev_out = !oe_n && (!rom_cs_n || (!ram_cs_n && we_n));
  always_comb begin
    if (!oe_n && !rom_cs_n) bus_din = rom_val(bus_addr);
    else if (!oe_n && !ram_cs_n && we_n)
      bus_din = (dev_v[bus_addr[11:0]] && dev_tag[bus_addr[11:0]] == bus_addr)
                ? dev_mem[bus_addr[11:0]] : 8'hA5;
    else bus_din = 8'hEE;
  end

  int          ov_len = 0;
  int          since_oe = 100;
  logic        prev_we_n = 1'b1;
  logic [17:0] w_addr;
  logic [7:0]  w_data;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!rom_cs_n && !ram_cs_n) begin
        fails++; $display("FAIL R1 both selects low rom=%b ram=%b exp one high", rom_cs_n, ram_cs_n);
      end
      if (bus_drive && dev_out) begin
        fails++; $display("FAIL R6 contention drive=%b dev=%b exp 0", bus_drive, dev_out);
      end
      if (bus_drive && since_oe < exp_ta()) begin
        fails++; $display("FAIL R6 drive after %0d cycles exp >= %0d", since_oe, exp_ta());
      end
      if (!ram_cs_n && !we_n) begin
        if (ov_len == 0 && prev_we_n) begin
          fails++; $display("FAIL R4 we_n not leading select got %b exp 0", prev_we_n);
        end
        if (!bus_drive) begin
          fails++; $display("FAIL R4 data not driven got %b exp 1", bus_drive);
        end
        ov_len++; w_addr = bus_addr; w_data = bus_dout;
      end else if (ov_len > 0) begin
        checks++;
        if (ov_len != exp_pw()) begin
          fails++; $display("FAIL R4 overlap %0d exp %0d", ov_len, exp_pw());
        end
        dev_mem[w_addr[11:0]] = w_data; dev_tag[w_addr[11:0]] = w_addr; dev_v[w_addr[11:0]] = 1;
        ov_len = 0;
      end
      if (!oe_n) since_oe = 0; else if (since_oe < 100) since_oe++;
      prev_we_n = we_n;
    end
  end

  // ---- checking helpers ----
  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++; $display("FAIL %s got %0h exp %0h", rq, act, exp);
    end
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic do_op(input bit wr, input bit ram, input logic [17:0] a, input logic [7:0] d,
                       output logic [7:0] rd, output int lat, output bit got_err);
    while (busy) @(negedge clk);
    req = 1; req_write = wr; req_ram = ram; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 0;
    lat = 1;
    while (!rdy && !err && lat < 1000) begin @(negedge clk); lat++; end
    rd = rd_data; got_err = err;
  endtask

  function automatic logic [7:0] ref_read(input logic [17:0] ma);
    if (ref_v[ma[11:0]] && ref_tag[ma[11:0]] == ma) return ref_mem[ma[11:0]];
    return 8'hA5;
  endfunction

  task automatic op_check(input bit wr, input bit ram, input logic [17:0] a, input logic [7:0] d);
    logic [7:0] rd; int lat; bit e; logic [17:0] ma;
    ma = clip(ram, a);
    do_op(wr, ram, a, d, rd, lat, e);
    if (wr && !ram) begin
      chk(e && lat == 1, "R7 rom write err latency", lat, 1);
      chk(rom_cs_n && ram_cs_n && we_n && !busy, "R7 no bus activity", {rom_cs_n, ram_cs_n, we_n, busy}, 4'b1110);
    end else if (wr) begin
      chk(!e && lat == exp_pw() + 3, "R4 write ready latency", lat, exp_pw() + 3);
      ref_mem[ma[11:0]] = d; ref_tag[ma[11:0]] = ma; ref_v[ma[11:0]] = 1;
    end else begin
      chk(lat == exp_rd() + 1, ram ? "R3 read latency" : "R2 read latency R9", lat, exp_rd() + 1);
      if (ram) chk(rd == ref_read(ma), "R3 ram read data R5", rd, ref_read(ma));
      else     chk(rd == rom_val(a), "R2 rom read data R5", rd, rom_val(a));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; $display("FAIL watchdog expired got hang exp finish");
    report();
  end

  initial begin
    logic [7:0] rd; int lat; bit e;
    for (int i = 0; i < 4096; i++) begin dev_v[i] = 0; ref_v[i] = 0; end
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!rdy && !err && !busy, "R1 reset handshake", {rdy, err, busy}, 0);
    chk(rom_cs_n && ram_cs_n && oe_n && we_n && !bus_drive, "R1 reset bus idle",
        {rom_cs_n, ram_cs_n, oe_n, we_n, bus_drive}, 5'b11110);
    rst_n = 1;
    @(negedge clk);
    // R2/R5 full-width ROM address
    op_check(0, 0, 18'h3FFFF, 0);
    chk(bus_addr == 18'h3FFFF, "R5 rom address untouched", bus_addr, 18'h3FFFF);
    // R5 aliasing of RAM high bits
    op_check(1, 1, 18'h30123, 8'h5A);
    op_check(0, 1, 18'h00123, 0);
    op_check(0, 1, 18'h20123, 0);
    // R8 ready is single-cycle: check the cycle after a write's ready
    do_op(1, 1, 18'h00456, 8'hC3, rd, lat, e);
    ref_mem[12'h456] = 8'hC3; ref_tag[12'h456] = 18'h00456; ref_v[12'h456] = 1;
    @(negedge clk);
    chk(!rdy, "R8 rdy single cycle", rdy, 0);
    // R7 rejected ROM write leaves RAM alone, err single cycle
    op_check(1, 0, 18'h00456, 8'h11);
    @(negedge clk);
    chk(!err, "R8 err single cycle", err, 0);
    op_check(0, 1, 18'h00456, 0);
    // R8 request during busy is ignored
    while (busy) @(negedge clk);
    req = 1; req_write = 0; req_ram = 1; req_addr = 18'h00456;
    @(negedge clk); req = 0;
    @(negedge clk);
    req = 1; req_write = 1; req_ram = 1; req_addr = 18'h00456; req_wdata = 8'h77;
    @(negedge clk); req = 0;
    chk(busy, "R8 still busy", busy, 1);
    op_check(0, 1, 18'h00456, 0);
    // R8 back-to-back: write then read issued on the ready cycle
    op_check(1, 1, 18'h00789, 8'h3E);
    op_check(0, 1, 18'h00789, 0);
    op_check(1, 1, 18'h0078A, 8'h4F);
    op_check(1, 1, 18'h0078B, 8'h50);
    op_check(0, 0, 18'h1ABCD, 0);
    // randomized mix
    for (int k = 0; k < 300; k++) begin
      bit wr = $urandom_range(0, 1);
      bit ram = ($urandom_range(0, 3) != 0);
      logic [17:0] a = {$urandom_range(0, 3), 4'h0, 12'($urandom_range(0, 31))};
      op_check(wr, ram, a, 8'($urandom));
    end
    repeat (20) @(negedge clk);
    report();
  end
endmodule